// File: doc/BRIEF.md
# Three-Wire Serial Frame Receiver

This block takes serial control frames carried on three lines: a bus clock, a data line and an enable line. All three are sampled by the system clock `clk`, so the bus clock must be several times slower than `clk`. A frame opens when enable rises. Each rising edge of the bus clock that arrives while enable is high shifts one data bit into the receiver and advances a bit count. Falling bus-clock edges at fixed counts move groups of received bits into their output latches. The fall of enable can also close a short divider frame.

The same receiver accepts three frame lengths. An 18-bit frame carries 4 band bits and a 14-bit divider ratio. A 19-bit frame carries 4 band bits and a 15-bit ratio. A 34-bit frame carries the 15-bit ratio, followed by 7 test bits and 8 feature bits. Frames that end early keep only the groups that were fully received. Bits beyond the 34th are dropped. The block strobes the divider whenever a new ratio is latched. A separate strobe marks that the top divider bit was forced to zero because the frame was short.

Top module: `tw_frame_rx`

## Requirements
- R1: After reset, `band_q` is 0, `div_ratio` is 256, `test_q` and `feat_q` are 0, and `div_load` and `msb_clear` are low.
- R2: On the falling bus-clock edge that ends bit 4 of a frame, `band_q` takes the first four bits received, with bit 1 going to `band_q[3]`.
- R3: On the falling bus-clock edge that ends bit 19, `div_ratio` takes bits 5 to 19 with bit 5 as MSB, `div_load` pulses high for exactly one `clk` cycle, and `msb_clear` stays low.
- R4: When enable falls after exactly 18 bits, `div_ratio` becomes bits 5 to 18 with bit 5 at position 13 and position 14 cleared, and `div_load` and `msb_clear` pulse together for one cycle.
- R5: On the falling edge that ends bit 34, `test_q` takes bits 20 to 26 (bit 20 to `test_q[6]`) and `feat_q` takes bits 27 to 34 (bit 27 to `feat_q[7]`).
- R6: Bits after the 34th in a frame change no output.
- R7: A frame that ends with enable falling after 5 to 17 bits leaves `div_ratio` unchanged and gives no `div_load`, while its band bits, if complete, are kept.
- R8: Bus-clock edges while enable is low change no output and give no strobe.
- R9: A rising edge of enable restarts the bit count, so a frame that follows a cut-off frame counts from its own first bit.
- R10: Every output change takes effect on the second `clk` rising edge after the bus edge that causes it is first present at the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| bus_clk | input | 1 | Serial bus clock |
| bus_data | input | 1 | Serial data, taken on bus clock rise |
| bus_en | input | 1 | Frame enable, high during a frame |
| band_q | output | 4 | Latched band bits |
| div_ratio | output | 15 | Latched divider ratio |
| div_load | output | 1 | One-cycle strobe when a new ratio is latched |
| msb_clear | output | 1 | One-cycle strobe when a short frame forced the ratio MSB to zero |
| test_q | output | 7 | Latched test bits |
| feat_q | output | 8 | Latched feature bits |

## Verification
The hardest case to reach is the boundary between frame lengths. The 18-bit load happens only when enable falls at a count of exactly 18. Neighbouring counts must not disturb the ratio, and a count of 19 must have loaded already, on the clock edge. The stimulus drives frames whose lengths step across 4, 9, 12, 18, 19, 34 and 40 bits. It also drives a cut-off frame followed directly by a new one, and a burst of bus clocks while enable is low. Each frame carries a distinct bit pattern, so a wrong slice or an off-by-one count shows up as a mismatch against the behavioural model.

// File: rtl/tw_frame_rx.sv
module tw_frame_rx #(
  parameter int BAND_W    = 4,
  parameter int DIV_W     = 15,
  parameter int TEST_W    = 7,
  parameter int FEAT_W    = 8,
  parameter int DIV_RESET = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clk,
  input  logic              bus_data,
  input  logic              bus_en,
  output logic [BAND_W-1:0] band_q,
  output logic [DIV_W-1:0]  div_ratio,
  output logic              div_load,
  output logic              msb_clear,
  output logic [TEST_W-1:0] test_q,
  output logic [FEAT_W-1:0] feat_q
);
  localparam int BAND_END  = BAND_W;
  localparam int DIV_END   = BAND_W + DIV_W;
  localparam int SHORT_END = DIV_END - 1;
  localparam int FRAME_END = DIV_END + TEST_W + FEAT_W;
  localparam int CNT_MAX   = FRAME_END + 1;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int TAIL_W    = TEST_W + FEAT_W;
  localparam int SR_W      = (DIV_W > TAIL_W) ? DIV_W : TAIL_W;

  logic             s_clk, p_clk, s_en, p_en, s_dat;
  logic [CNT_W-1:0] cnt;
  logic [SR_W-1:0]  shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s_clk, p_clk, s_en, p_en, s_dat} <= '0;
    else        {s_clk, p_clk, s_en, p_en, s_dat} <= {bus_clk, s_clk, bus_en, s_en, bus_data};

  wire clk_rise = s_en & s_clk & ~p_clk;
  wire clk_fall = s_en & ~s_clk & p_clk;
  wire en_rise  = s_en & ~p_en;
  wire en_fall  = ~s_en & p_en;

  wire at_band  = cnt == CNT_W'(BAND_END);
  wire at_div   = cnt == CNT_W'(DIV_END);
  wire at_short = cnt == CNT_W'(SHORT_END);
  wire at_frame = cnt == CNT_W'(FRAME_END);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (en_rise) begin
      cnt <= '0;
    end else if (clk_rise) begin
      if (cnt < CNT_W'(FRAME_END)) shreg <= {shreg[SR_W-2:0], s_dat};
      if (cnt < CNT_W'(CNT_MAX))   cnt   <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      band_q    <= '0;
      div_ratio <= DIV_W'(DIV_RESET);
      div_load  <= 1'b0;
      msb_clear <= 1'b0;
      test_q    <= '0;
      feat_q    <= '0;
    end else begin
      div_load  <= 1'b0;
      msb_clear <= 1'b0;
      if (clk_fall && at_band) band_q <= shreg[BAND_W-1:0];
      if (clk_fall && at_div) begin
        div_ratio <= shreg[DIV_W-1:0];
        div_load  <= 1'b1;
      end
      if (clk_fall && at_frame) begin
        test_q <= shreg[TAIL_W-1:FEAT_W];
        feat_q <= shreg[FEAT_W-1:0];
      end
      if (en_fall && at_short) begin
        div_ratio <= {1'b0, shreg[DIV_W-2:0]};
        div_load  <= 1'b1;
        msb_clear <= 1'b1;
      end
    end
endmodule

module tw_frame_rx_chk #(
  parameter int DIV_W   = 15,
  parameter int BAND_W  = 4,
  parameter int CNT_W   = 6,
  parameter int CNT_MAX = 35
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic [BAND_W-1:0] band_q,
  input logic [DIV_W-1:0]  div_ratio,
  input logic              div_load,
  input logic              msb_clear,
  input logic [CNT_W-1:0]  cnt
);
  a_r3_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    div_load |=> !div_load);

  a_r4_clear_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    msb_clear |-> (div_load && !div_ratio[DIV_W-1]));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bus_en, 2) && !$past(bus_en, 3)) |->
      ($stable(band_q) && $stable(div_ratio) && !div_load));

  a_r6_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CNT_MAX));
endmodule

bind tw_frame_rx tw_frame_rx_chk #(
  .DIV_W(DIV_W), .BAND_W(BAND_W), .CNT_W(CNT_W), .CNT_MAX(CNT_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .band_q(band_q),
  .div_ratio(div_ratio), .div_load(div_load), .msb_clear(msb_clear), .cnt(cnt)
);

// File: tb/test_tw_frame_rx.sv
module test_tw_frame_rx;
  logic clk = 0, rst_n = 0, bus_clk = 0, bus_data = 0, bus_en = 0;
  logic [3:0]  band_q;
  logic [14:0] div_ratio;
  logic        div_load, msb_clear;
  logic [6:0]  test_q;
  logic [7:0]  feat_q;

  always #2 clk = ~clk;

  tw_frame_rx i_tw_frame_rx (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data), .bus_en(bus_en),
    .band_q(band_q), .div_ratio(div_ratio), .div_load(div_load), .msb_clear(msb_clear),
    .test_q(test_q), .feat_q(feat_q)
  );

  int tests = 0, fails = 0, loads = 0, clears = 0, cyc = 0;
  bit done = 0;

  bit bits[$];
  int m_cnt;
  logic lc, le;
  logic [3:0] m_band, e_band;
  logic [14:0] m_div, e_div;
  logic m_load, e_load, m_clr, e_clr;
  logic [6:0] m_test, e_test;
  logic [7:0] m_feat, e_feat;

  always @(posedge clk) begin
    if (!rst_n) begin
      bits.delete(); m_cnt = 0; lc = 0; le = 0;
      m_band = 0; m_div = 256; m_load = 0; m_clr = 0; m_test = 0; m_feat = 0;
      e_band = 0; e_div = 256; e_load = 0; e_clr = 0; e_test = 0; e_feat = 0;
    end else begin
      e_band = m_band; e_div = m_div; e_load = m_load; e_clr = m_clr;
      e_test = m_test; e_feat = m_feat;
      m_load = 0; m_clr = 0;
      if (bus_en && !le) begin
        bits.delete(); m_cnt = 0;
      end else begin
        if (bus_en && bus_clk && !lc && m_cnt < 35) begin
          if (bits.size() < 34) bits.push_back(bus_data);
          m_cnt++;
        end
        if (bus_en && !bus_clk && lc) begin
          if (m_cnt == 4) for (int i = 0; i < 4; i++) m_band[3-i] = bits[i];
          if (m_cnt == 19) begin
            for (int i = 0; i < 15; i++) m_div[14-i] = bits[4+i];
            m_load = 1;
          end
          if (m_cnt == 34) begin
            for (int i = 0; i < 7; i++) m_test[6-i] = bits[19+i];
            for (int i = 0; i < 8; i++) m_feat[7-i] = bits[26+i];
          end
        end
        if (!bus_en && le && m_cnt == 18) begin
          m_div = 0;
          for (int i = 0; i < 14; i++) m_div[13-i] = bits[4+i];
          m_load = 1; m_clr = 1;
        end
      end
      lc = bus_clk; le = bus_en;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if ({band_q, div_ratio, div_load, msb_clear, test_q, feat_q} !==
          {e_band, e_div, e_load, e_clr, e_test, e_feat}) begin
        fails++;
        $display("FAIL R10 per-clock model: act %h exp %h",
          {band_q, div_ratio, div_load, msb_clear, test_q, feat_q},
          {e_band, e_div, e_load, e_clr, e_test, e_feat});
      end
      if (div_load) loads++;
      if (msb_clear) clears++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: act %0d cycles exp completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act %h exp %h", r, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    bus_data = b; tick(2);
    bus_clk = 1; tick(3);
    bus_clk = 0; tick(3);
  endtask

  task automatic frame(int n, logic [39:0] v);
    bus_en = 1; tick(3);
    for (int i = 0; i < n; i++) send_bit(v[i]);
    bus_en = 0; tick(4);
  endtask

  function automatic logic [3:0] f_band(logic [39:0] v);
    return {v[0], v[1], v[2], v[3]};
  endfunction
  function automatic logic [14:0] f_div(logic [39:0] v, int n);
    logic [14:0] r = 0;
    for (int i = 0; i < n; i++) r[n-1-i] = v[4+i];
    return r;
  endfunction
  function automatic logic [14:0] f_tail(logic [39:0] v);
    logic [14:0] r = 0;
    for (int i = 0; i < 15; i++) r[14-i] = v[19+i];
    return r;
  endfunction

  initial begin
    logic [39:0] va, vb, vc, vd, ve;
    int l0, c0;
    logic [14:0] dsave;
    va = 40'hA5_3C96_E1B7;
    vb = 40'h5A_C369_1E48;
    vc = 40'h3F_0F55_AA99;
    vd = 40'hC0_F0AA_5566;
    ve = 40'h96_69A5_5A3C;
    tick(5); rst_n = 1; tick(2);

    chk("R1 band", 32'(band_q), 0);
    chk("R1 div", 32'(div_ratio), 256);
    chk("R1 strobes", {div_load, msb_clear}, 0);
    chk("R1 test/feat", {test_q, feat_q}, 0);

    l0 = loads; c0 = clears;
    frame(19, va);
    chk("R2 band", 32'(band_q), 32'(f_band(va)));
    chk("R3 div", 32'(div_ratio), 32'(f_div(va, 15)));
    chk("R3 one load", loads - l0, 1);
    chk("R3 no clear", clears - c0, 0);

    l0 = loads; c0 = clears;
    frame(18, vb);
    chk("R4 div", 32'(div_ratio), 32'(f_div(vb, 14)));
    chk("R4 load and clear", {16'(loads - l0), 16'(clears - c0)}, {16'd1, 16'd1});

    frame(34, vc);
    chk("R5 div", 32'(div_ratio), 32'(f_div(vc, 15)));
    chk("R5 test/feat", 32'({test_q, feat_q}), 32'(f_tail(vc)));

    frame(40, vd);
    chk("R6 tail from bits 20..34", 32'({test_q, feat_q}), 32'(f_tail(vd)));
    chk("R6 band", 32'(band_q), 32'(f_band(vd)));

    dsave = div_ratio; l0 = loads;
    frame(9, ve);
    chk("R7 band kept", 32'(band_q), 32'(f_band(ve)));
    chk("R7 div unchanged", 32'(div_ratio), 32'(dsave));
    frame(12, va);
    chk("R7 div unchanged 12", 32'(div_ratio), 32'(dsave));
    chk("R7 no load", loads - l0, 0);

    l0 = loads;
    for (int i = 0; i < 20; i++) send_bit(i[0]);
    chk("R8 band", 32'(band_q), 32'(f_band(va)));
    chk("R8 div", 32'(div_ratio), 32'(dsave));
    chk("R8 no load", loads - l0, 0);

    frame(2, vb);
    frame(4, vc);
    chk("R9 band from new frame", 32'(band_q), 32'(f_band(vc)));

    bus_en = 1; tick(3);
    for (int i = 0; i < 3; i++) send_bit(vd[i]);
    bus_data = vd[3]; tick(2); bus_clk = 1; tick(3);
    chk("R10 before fall", 32'(band_q), 32'(f_band(vc)));
    bus_clk = 0; tick(1);
    chk("R10 one cycle", 32'(band_q), 32'(f_band(vc)));
    tick(1);
    chk("R10 two cycles", 32'(band_q), 32'(f_band(vd)));
    bus_en = 0; tick(4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule